// File: doc/BRIEF.md
# Mailbox Handshake Status Controller

This block keeps the handshake state for a set of functions that exchange short messages through shared mailbox memories. Function 0 is the physical function (PF); functions 1 to NUM_FN-1 are virtual functions (VFs). Every function owns a command register, and the PF also owns a target selector and an acknowledgment-clear register. The block decodes writes to these registers and tracks three kinds of state:

- the outgoing-busy and incoming-pending bits of each function;
- a bounded queue of VFs whose messages wait for the PF;
- one acknowledgment bit for each VF that has taken a message from the PF.

Writes toward a function's outgoing mailbox memory pass through the block. The block lets each write through as a one-hot write enable, or blocks it while that function's last send still waits for its answer. When a write is blocked and the ERR_EN option is set, an error flag is raised. A combinational read port returns a 32-bit status word for any function number.

Top module: `mbox_status_ctrl`

## Requirements
- R1: The status word places incoming-pending in bit 0, outgoing-busy in bit 1, acknowledgment-pending in bit 2 and the queue-head function number in bits [11:4]. Bit 3 and bits [31:12] are zero. A read of a function number at or above NUM_FN returns zero, and after reset every function reads zero.
- R2: A command write (wr_sel=0) with wr_data bit 0 (send) from a VF sets that VF's busy bit and appends its number to the PF queue. This happens only when the VF is not already busy and the queue is not full; otherwise the write has no effect.
- R3: A mailbox write (wr_sel=3) drives the one-hot omm_we bit of the writing function when that function is not busy. When the function is busy, omm_we stays all zero and wr_err is 1 (with ERR_EN=1).
- R4: A PF write to the target register (wr_sel=1) stores wr_data[7:0] when that value lies in 1..NUM_FN-1, and is ignored otherwise. A PF send marks the target VF busy-from-PF and sets that VF's incoming-pending bit. The PF send is ignored while the target is 0. The PF's outgoing-busy bit shows the busy-from-PF state of the current target.
- R5: A command write with wr_data bit 1 (receive) from a VF clears that VF's incoming-pending bit and ends any busy-from-PF state for that VF.
- R6: The PF's incoming-pending bit is 1 exactly while the queue holds an entry. A PF receive command removes the head entry and clears the busy bit of that VF. A PF receive command on an empty queue changes nothing.
- R7: The PF's source field shows the VF number at the head of the queue, or 0 when the queue is empty. The field is 0 in every VF status word.
- R8: A VF receive that ends a busy-from-PF state sets that VF's acknowledgment bit. The PF's acknowledgment-pending bit is the OR of all acknowledgment bits. A PF write with wr_sel=2, wr_data bit 8 set and wr_data[7:0]=n clears bit n.
- R9: A send from a VF that is not busy, made while the queue holds QDEPTH entries, is refused. The VF's busy bit stays 0 and the queue does not change.
- R10: Writes with wr_fn at or above NUM_FN change no state and raise neither omm_we nor wr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_fn | input | 8 | Function performing the write |
| wr_sel | input | 2 | 0 command, 1 target, 2 ack clear, 3 mailbox memory |
| wr_data | input | 32 | Write data |
| omm_we | output | NUM_FN | Passed outgoing-mailbox write enable, one-hot |
| wr_err | output | 1 | Blocked mailbox write (error response) |
| rd_fn | input | 8 | Function whose status is read |
| rd_status | output | 32 | Status word of rd_fn |

## Verification
The bound checker watches a set of properties on every clock:

- the reserved status bits stay zero;
- omm_we is never more than one-hot and stays all zero for a busy writer;
- an accepted VF send always leaves the VF busy, and a refused one leaves it clear;
- the queue count never exceeds its depth;
- every new acknowledgment bit traces back to a VF receive command.

Other behaviours only show up across longer scenarios: FIFO ordering of the source field over several pops, target switching for the PF's busy view, ignored out-of-range targets and writers, and acknowledgment clearing. The bench's reference model covers these through directed sequences and a long random write stream.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int FN_W        = 8;
   localparam int CMD_SEND    = 0;
   localparam int CMD_RCV     = 1;
   localparam int ACK_CLR_BIT = 8;
   localparam int ST_IPEND    = 0;
   localparam int ST_OBUSY    = 1;
   localparam int ST_ACK      = 2;
   localparam int ST_SRC_LSB  = 4;

   typedef enum logic [1:0] {
      SEL_CMD    = 2'd0,
      SEL_TGT    = 2'd1,
      SEL_ACKCLR = 2'd2,
      SEL_OMM    = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/mbox_evq.sv
module mbox_evq #(
   parameter int DEPTH = 4,
   parameter int W     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [W-1:0]                  push_data,
   input  logic                          pop,
   output logic [W-1:0]                  head,
   output logic                          empty,
   output logic                          full,
   output logic [$clog2(DEPTH+1)-1:0]    count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  slot [DEPTH];
   logic [AW-1:0] rd_p, wr_p;
   logic          do_push, do_pop;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == LAST) ? '0 : p + AW'(1);
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = empty ? '0 : slot[rd_p];

   always_ff @(posedge clk) begin
      if (do_push) slot[wr_p] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_p  <= '0;
         wr_p  <= '0;
         count <= '0;
      end else begin
         if (do_push) wr_p <= bump(wr_p);
         if (do_pop)  rd_p <= bump(rd_p);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/mbox_sr_vec.sv
module mbox_sr_vec #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/mbox_status_ctrl.sv
module mbox_status_ctrl import mbox_pkg::*; #(
   parameter int NUM_FN = 8,
   parameter int QDEPTH = 4,
   parameter bit ERR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FN_W-1:0]   wr_fn,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   output logic [NUM_FN-1:0] omm_we,
   output logic              wr_err,
   input  logic [FN_W-1:0]   rd_fn,
   output logic [31:0]       rd_status
);
   localparam int IW = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;
   localparam int CW = $clog2(QDEPTH + 1);
   localparam logic [FN_W:0]     FN_LIM  = (FN_W + 1)'(NUM_FN);
   localparam logic [NUM_FN-1:0] VF_MASK = ~(NUM_FN'(1));

   if (NUM_FN < 2 || NUM_FN > 256) begin : g_bad_fn
      $error("mbox_status_ctrl: NUM_FN must lie in 2..256");
   end
   if (QDEPTH < 1) begin : g_bad_depth
      $error("mbox_status_ctrl: QDEPTH must be at least 1");
   end

   wr_sel_e           sel;
   logic              fn_ok, is_pf, data_ok, rd_ok;
   logic [IW-1:0]     fn_idx, data_idx, rd_idx, tgt_q;
   logic [FN_W-1:0]   data_fn;
   logic [NUM_FN-1:0] fn_oh, tgt_oh, data_oh, head_oh;
   logic [NUM_FN-1:0] vf_busy, vf_ipend, pf_busy, ack;
   logic              do_cmd, pf_send, pf_rcv, vf_send, vf_rcv;
   logic              ack_clr, tgt_wr, omm_try, busy_cur;
   logic              q_empty, q_full;
   logic [IW-1:0]     q_head;
   logic [CW-1:0]     q_count;
   logic              unused_bits;

   function automatic logic [NUM_FN-1:0] onehot(input logic [IW-1:0] i);
      logic [NUM_FN-1:0] v;
      v = '0;
      v[i] = 1'b1;
      return v;
   endfunction

   assign sel         = wr_sel_e'(wr_sel);
   assign fn_ok       = {1'b0, wr_fn} < FN_LIM;
   assign is_pf       = (wr_fn == '0);
   assign fn_idx      = wr_fn[IW-1:0];
   assign data_fn     = wr_data[FN_W-1:0];
   assign data_ok     = {1'b0, data_fn} < FN_LIM;
   assign data_idx    = data_fn[IW-1:0];
   assign unused_bits = ^wr_data[31:ACK_CLR_BIT+1];

   assign fn_oh   = fn_ok ? onehot(fn_idx) : '0;
   assign tgt_oh  = onehot(tgt_q);
   assign data_oh = onehot(data_idx);
   assign head_oh = onehot(q_head);

   // command decode
   assign do_cmd  = wr_en && fn_ok && (sel == SEL_CMD);
   assign pf_send = do_cmd && is_pf && wr_data[CMD_SEND] && (tgt_q != '0);
   assign pf_rcv  = do_cmd && is_pf && wr_data[CMD_RCV] && !q_empty;
   assign vf_send = do_cmd && !is_pf && wr_data[CMD_SEND] && !vf_busy[fn_idx] && !q_full;
   assign vf_rcv  = do_cmd && !is_pf && wr_data[CMD_RCV];
   assign ack_clr = wr_en && fn_ok && is_pf && (sel == SEL_ACKCLR) &&
                    wr_data[ACK_CLR_BIT] && data_ok;
   assign tgt_wr  = wr_en && fn_ok && is_pf && (sel == SEL_TGT) &&
                    data_ok && (data_fn != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      tgt_q <= '0;
      else if (tgt_wr) tgt_q <= data_idx;
   end

   // per-function state, set wins over clear
   mbox_sr_vec #(.W(NUM_FN)) u_vf_busy (
      .clk(clk), .rst_n(rst_n),
      .set(vf_send ? (fn_oh & VF_MASK) : '0),
      .clr(pf_rcv ? head_oh : '0),
      .q(vf_busy));

   mbox_sr_vec #(.W(NUM_FN)) u_vf_ipend (
      .clk(clk), .rst_n(rst_n),
      .set(pf_send ? (tgt_oh & VF_MASK) : '0),
      .clr(vf_rcv ? fn_oh : '0),
      .q(vf_ipend));

   mbox_sr_vec #(.W(NUM_FN)) u_pf_busy (
      .clk(clk), .rst_n(rst_n),
      .set(pf_send ? (tgt_oh & VF_MASK) : '0),
      .clr(vf_rcv ? fn_oh : '0),
      .q(pf_busy));

   mbox_sr_vec #(.W(NUM_FN)) u_ack (
      .clk(clk), .rst_n(rst_n),
      .set(vf_rcv ? (fn_oh & pf_busy & VF_MASK) : '0),
      .clr(ack_clr ? data_oh : '0),
      .q(ack));

   mbox_evq #(.DEPTH(QDEPTH), .W(IW)) u_evq (
      .clk(clk), .rst_n(rst_n),
      .push(vf_send), .push_data(fn_idx),
      .pop(pf_rcv), .head(q_head),
      .empty(q_empty), .full(q_full), .count(q_count));

   // outgoing mailbox write gating
   assign omm_try  = wr_en && fn_ok && (sel == SEL_OMM);
   assign busy_cur = is_pf ? pf_busy[tgt_q] : vf_busy[fn_idx];
   assign omm_we   = (omm_try && !busy_cur) ? fn_oh : '0;

   if (ERR_EN) begin : g_err
      assign wr_err = omm_try && busy_cur;
   end else begin : g_no_err
      assign wr_err = 1'b0;
   end

   // status read
   assign rd_ok  = {1'b0, rd_fn} < FN_LIM;
   assign rd_idx = rd_fn[IW-1:0];

   always_comb begin
      rd_status = '0;
      if (rd_ok) begin
         if (rd_fn == '0) begin
            rd_status[ST_IPEND] = !q_empty;
            rd_status[ST_OBUSY] = pf_busy[tgt_q];
            rd_status[ST_ACK]   = |ack;
            rd_status[ST_SRC_LSB +: FN_W] = FN_W'(q_head);
         end else begin
            rd_status[ST_IPEND] = vf_ipend[rd_idx];
            rd_status[ST_OBUSY] = vf_busy[rd_idx];
         end
      end
   end
endmodule

// File: rtl/mbox_status_chk.sv
module mbox_status_chk import mbox_pkg::*; #(
   parameter int NUM_FN = 8,
   parameter int QDEPTH = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [FN_W-1:0]               wr_fn,
   input logic [1:0]                    wr_sel,
   input logic [31:0]                   wr_data,
   input logic [31:0]                   rd_status,
   input logic [NUM_FN-1:0]             omm_we,
   input logic                          wr_err,
   input logic [NUM_FN-1:0]             vf_busy,
   input logic [NUM_FN-1:0]             pf_busy,
   input logic [NUM_FN-1:0]             ack,
   input logic [((NUM_FN > 1) ? $clog2(NUM_FN) : 1)-1:0] tgt_q,
   input logic                          q_full,
   input logic [$clog2(QDEPTH+1)-1:0]   q_count
);
   localparam int IW = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;
   localparam int CW = $clog2(QDEPTH + 1);
   localparam logic [FN_W:0] FN_LIM = (FN_W + 1)'(NUM_FN);

   logic          fn_in, vf_in, send_try, busy_now, omm_wr, rcv_wr;
   logic [IW-1:0] idx, idx_q;

   assign idx      = wr_fn[IW-1:0];
   assign fn_in    = {1'b0, wr_fn} < FN_LIM;
   assign vf_in    = fn_in && (wr_fn != '0);
   assign send_try = wr_en && (wr_sel == SEL_CMD) && wr_data[CMD_SEND] && vf_in;
   assign rcv_wr   = wr_en && (wr_sel == SEL_CMD) && wr_data[CMD_RCV] && vf_in;
   assign omm_wr   = wr_en && (wr_sel == SEL_OMM) && fn_in;
   assign busy_now = (wr_fn == '0) ? pf_busy[tgt_q] : vf_busy[idx];

   always_ff @(posedge clk) idx_q <= idx;

   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status[31:12] == '0) && !rd_status[3]);

   p_send_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (send_try && !q_full && !vf_busy[idx]) |=> vf_busy[idx_q]);

   p_omm_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(omm_we));

   p_omm_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (omm_wr && busy_now) |-> (omm_we == '0));

   p_omm_err_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (omm_wr && busy_now));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(QDEPTH));

   p_ack_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack & ~$past(ack)) != '0) |-> $past(rcv_wr));

   p_full_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (send_try && q_full && !vf_busy[idx]) |=> !vf_busy[idx_q]);
endmodule

bind mbox_status_ctrl mbox_status_chk #(.NUM_FN(NUM_FN), .QDEPTH(QDEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fn(wr_fn), .wr_sel(wr_sel),
   .wr_data(wr_data), .rd_status(rd_status), .omm_we(omm_we), .wr_err(wr_err),
   .vf_busy(vf_busy), .pf_busy(pf_busy), .ack(ack), .tgt_q(tgt_q),
   .q_full(q_full), .q_count(q_count));

// File: tb/tb_mbox_status_ctrl.sv
`timescale 1ns/1ps
module tb_mbox_status_ctrl;
   localparam int NUM_FN = 8;
   localparam int QDEPTH = 4;
   localparam bit ERR_EN = 1'b1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        wr_fn = '0;
   logic [1:0]        wr_sel = '0;
   logic [31:0]       wr_data = '0;
   logic [NUM_FN-1:0] omm_we;
   logic              wr_err;
   logic [7:0]        rd_fn = '0;
   logic [31:0]       rd_status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   int q[$];
   bit [NUM_FN-1:0] vbusy, vipend, pbusy, ackv;
   int tgt;

   always #2.5 clk = ~clk;

   mbox_status_ctrl #(.NUM_FN(NUM_FN), .QDEPTH(QDEPTH), .ERR_EN(ERR_EN)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fn(wr_fn), .wr_sel(wr_sel),
      .wr_data(wr_data), .omm_we(omm_we), .wr_err(wr_err),
      .rd_fn(rd_fn), .rd_status(rd_status));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_status(input int f);
      logic [31:0] s;
      s = '0;
      if (f >= NUM_FN) return s;
      if (f == 0) begin
         s[0]    = (q.size() != 0);
         s[1]    = pbusy[tgt];
         s[2]    = |ackv;
         s[11:4] = (q.size() != 0) ? 8'(q[0]) : 8'd0;
      end else begin
         s[0] = vipend[f];
         s[1] = vbusy[f];
      end
      return s;
   endfunction

   task automatic model_reset();
      q.delete();
      vbusy = '0; vipend = '0; pbusy = '0; ackv = '0; tgt = 0;
   endtask

   task automatic model_write(input int f, input int s, input logic [31:0] d);
      int h;
      int dn;
      dn = int'(d[7:0]);
      if (f >= NUM_FN) return;
      case (s)
         0: if (f == 0) begin
               if (d[0] && tgt != 0) begin pbusy[tgt] = 1'b1; vipend[tgt] = 1'b1; end
               if (d[1] && q.size() != 0) begin h = q.pop_front(); vbusy[h] = 1'b0; end
            end else begin
               if (d[0] && !vbusy[f] && q.size() < QDEPTH) begin vbusy[f] = 1'b1; q.push_back(f); end
               if (d[1]) begin
                  vipend[f] = 1'b0;
                  if (pbusy[f]) begin pbusy[f] = 1'b0; ackv[f] = 1'b1; end
               end
            end
         1: if (f == 0 && dn >= 1 && dn < NUM_FN) tgt = dn;
         2: if (f == 0 && d[8] && dn < NUM_FN) ackv[dn] = 1'b0;
         default: ;
      endcase
   endtask

   task automatic compare_all();
      for (int f = 0; f <= NUM_FN; f++) begin
         rd_fn = 8'(f);
         #0.1;
         chk((f == 0) ? "R1 R4 R6 R7 R8 PF status" : "R1 R2 R5 R7 VF status",
             rd_status, exp_status(f));
      end
   endtask

   // one write: check gating before the edge, status after it
   task automatic do_wr(input int f, input int s, input logic [31:0] d);
      bit busy, try_omm;
      logic [NUM_FN-1:0] exp_we;
      @(negedge clk);
      wr_en = 1'b1; wr_fn = 8'(f); wr_sel = 2'(s); wr_data = d;
      #0.5;
      try_omm = (s == 3) && (f < NUM_FN);
      busy = (f < NUM_FN) ? ((f == 0) ? pbusy[tgt] : vbusy[f]) : 1'b0;
      exp_we = '0;
      if (try_omm && !busy) exp_we[f] = 1'b1;
      chk("R3 R10 omm_we", 32'(omm_we), 32'(exp_we));
      chk("R3 R10 wr_err", 32'(wr_err), 32'(try_omm && busy && ERR_EN));
      @(posedge clk);
      model_write(f, s, d);
      @(negedge clk);
      wr_en = 1'b0;
      #0.5;
      compare_all();
   endtask

   task automatic rd_is(input int f, input logic [31:0] exp, input string tag);
      rd_fn = 8'(f);
      #0.1;
      chk(tag, rd_status, exp);
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #0.5;
      compare_all();                                   // R1 reset state

      do_wr(9, 0, 32'h1);                              // R10 out-of-range send
      do_wr(8, 3, 32'h0);                              // R10 out-of-range mailbox write
      rd_is(0, 32'h0, "R10 nothing queued");

      do_wr(0, 3, 32'h0);                              // R3 PF write with no busy target
      do_wr(1, 0, 32'h1);                              // R2 VF1 send
      rd_is(1, 32'h2, "R2 VF1 busy");
      rd_is(0, 32'h11, "R6 R7 PF pending head 1");
      do_wr(1, 3, 32'h0);                              // R3 blocked
      do_wr(2, 3, 32'h0);                              // R3 passed
      do_wr(1, 0, 32'h1);                              // R2 resend while busy ignored

      do_wr(2, 0, 32'h1);
      do_wr(3, 0, 32'h1);
      do_wr(4, 0, 32'h1);                              // queue now full
      do_wr(5, 0, 32'h1);                              // R9 refused
      rd_is(5, 32'h0, "R9 VF5 stays idle");

      do_wr(0, 0, 32'h2);                              // R6 pop VF1
      rd_is(1, 32'h0, "R6 VF1 released");
      rd_is(0, 32'h21, "R7 head now 2");
      do_wr(0, 0, 32'h2);
      do_wr(0, 0, 32'h2);
      do_wr(0, 0, 32'h2);
      rd_is(0, 32'h0, "R6 R7 queue drained");
      do_wr(0, 0, 32'h2);                              // R6 pop on empty

      do_wr(0, 1, 32'h3);                              // R4 target 3
      do_wr(0, 0, 32'h1);                              // R4 PF send
      rd_is(0, 32'h2, "R4 PF busy toward 3");
      rd_is(3, 32'h1, "R4 VF3 pending");
      do_wr(0, 3, 32'h0);                              // R3 PF blocked
      do_wr(0, 1, 32'h0);                              // R4 target 0 ignored
      do_wr(0, 1, 32'h9);                              // R4 target 9 ignored
      rd_is(0, 32'h2, "R4 target kept");
      do_wr(3, 0, 32'h2);                              // R5 VF3 receive
      rd_is(3, 32'h0, "R5 VF3 cleared");
      rd_is(0, 32'h4, "R8 ack pending");
      do_wr(0, 2, 32'h3);                              // R8 clear without bit 8
      rd_is(0, 32'h4, "R8 clear needs bit 8");
      do_wr(0, 2, 32'h103);                            // R8 clear
      rd_is(0, 32'h0, "R8 ack cleared");

      for (int i = 0; i < 600; i++) begin
         int f;
         int s;
         logic [31:0] d;
         f = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(0, NUM_FN));
         s = int'($urandom_range(0, 3));
         d = 32'($urandom_range(0, NUM_FN));
         if (s == 0) d = 32'($urandom_range(1, 3));
         if ($urandom_range(0, 1) == 1) d[8] = 1'b1;
         do_wr(f, s, d);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         #(5.0 * 150000);
      join_any
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule